// File: doc/BRIEF.md
# Byte-Wide Hardware Stack Sequencer

This block keeps the 8-bit stack pointer of a small 8-bit processor core. It turns one stack request into a run of byte accesses on a synchronous RAM port, one access per clock. The stack lives in one fixed 256-byte page. The pointer supplies the low address byte and a parameter supplies the high byte. Six request kinds are supported: subroutine call, interrupt entry, return, return-from-interrupt, single-byte push and single-byte pop. Each kind moves its own frame of bytes in a fixed order.

The core raises one bit of a one-hot request vector for a single cycle while the sequencer is idle. The sequencer latches the program counter, status byte and data byte offered with the request. It then holds `busy` while it moves the frame and pulses `done` when the frame is complete. Restored bytes appear on registered outputs. Software sets the pointer through a load strobe, which stands in for the transfer-from-index-register instruction.

Top module: `stack_seq`

## Requirements
- R1: Every RAM access uses address {PAGE, low byte}, where PAGE is a parameter with default 0x01. The pointer wraps modulo 256: a write at pointer 0x00 leaves it at 0xFF, and a read with the pointer at 0xFF reads low byte 0x00 and leaves it at 0x00.
- R2: A write step stores the byte at the current pointer, and the pointer is one lower after that clock edge.
- R3: A read step first moves the pointer one higher, reads at the new pointer, and leaves the pointer there.
- R4: A call (request bit 0) writes PC[15:8] and then PC[7:0], so the pointer ends 2 lower. From 0xFF the bytes land at 0x01FF and 0x01FE, and the pointer ends at 0xFD.
- R5: Interrupt entry (request bit 1) writes PC[15:8], then PC[7:0], then the status byte, so the pointer ends 3 lower.
- R6: A return (request bit 2) reads PC low and then PC high into `pop_pcl` and `pop_pch`, so the pointer ends 2 higher.
- R7: Return-from-interrupt (request bit 3) reads the status byte, then PC low, then PC high, so the pointer ends 3 higher.
- R8: A push (request bit 4) writes `data_in` as one byte. A pop (request bit 5) reads one byte into `pop_data`. Each changes the pointer by 1.
- R9: `busy` rises in the cycle after acceptance, and the sequencer makes exactly one access in each busy cycle. A frame of N writes holds `busy` for N cycles. A frame of N reads holds `busy` for N+1 cycles, the last one with no access. `done` pulses for one cycle, in the first cycle after `busy` falls.
- R10: Requests made while `busy` is high are ignored. So is any request vector that does not have exactly one bit set.
- R11: When idle, `sp_load` loads `sp_load_val` into the pointer at the next edge, and any request in that same cycle is ignored. While `busy` is high, `sp_load` is ignored.
- R12: After reset the pointer is 0x00, `busy` and `done` are low, all popped outputs are 0x00, and no access is made.
- R13: The PC, status byte and data byte are taken at acceptance. Changing them later in the frame does not change the written bytes.
- R14: While `busy` is low, the popped outputs hold their values. A frame updates only the outputs that its reads target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req | input | 6 | One-hot request: 0 call, 1 interrupt entry, 2 return, 3 return-from-interrupt, 4 push, 5 pop |
| sp_load | input | 1 | Load the pointer from sp_load_val |
| sp_load_val | input | 8 | Value to load into the pointer |
| pc_in | input | 16 | Program counter to save |
| psw_in | input | 8 | Status byte to save |
| data_in | input | 8 | Byte to push |
| mem_addr | output | 16 | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable; data returns the next cycle |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| pop_pch | output | 8 | Restored PC high byte |
| pop_pcl | output | 8 | Restored PC low byte |
| pop_psw | output | 8 | Restored status byte |
| pop_data | output | 8 | Byte from a single pop |

## Verification
The bench builds the block with its default page, 0x01, and an 8-bit pointer. Every address the pointer can reach is therefore open to stimulus. Loading 0x00 and 0xFF puts the wrap at both ends of the page within a few cycles. A small memory in the bench reads one cycle late, like the target RAM, so the drain cycle of read frames and the timing of the captured outputs are exercised as they would be in the target system.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 8;
  localparam int OP_W   = 6;
  localparam int IDX_W  = 2;
  localparam int PC_W   = 2 * DATA_W;

  localparam int B_CALL = 0;
  localparam int B_IRQ  = 1;
  localparam int B_RET  = 2;
  localparam int B_RETI = 3;
  localparam int B_PUSH = 4;
  localparam int B_POP  = 5;

  typedef enum logic [2:0] {K_CALL, K_IRQ, K_RET, K_RETI, K_PUSH, K_POP} kind_t;
  typedef enum logic [1:0] {S_PCH, S_PCL, S_PSW, S_DAT} slot_t;

  function automatic kind_t decode_kind(input logic [OP_W-1:0] req);
    kind_t k;
    k = K_CALL;
    if (req[B_IRQ])  k = K_IRQ;
    if (req[B_RET])  k = K_RET;
    if (req[B_RETI]) k = K_RETI;
    if (req[B_PUSH]) k = K_PUSH;
    if (req[B_POP])  k = K_POP;
    return k;
  endfunction

  // index of the final byte in a frame
  function automatic logic [IDX_W-1:0] frame_last(input kind_t k);
    case (k)
      K_CALL, K_RET:  return IDX_W'(1);
      K_IRQ, K_RETI:  return IDX_W'(2);
      default:        return IDX_W'(0);
    endcase
  endfunction

  function automatic logic frame_writes(input kind_t k);
    return (k == K_CALL) || (k == K_IRQ) || (k == K_PUSH);
  endfunction

  function automatic slot_t frame_slot(input kind_t k, input logic [IDX_W-1:0] idx);
    case (k)
      K_CALL, K_IRQ: return (idx == 0) ? S_PCH : (idx == 1) ? S_PCL : S_PSW;
      K_RET:         return (idx == 0) ? S_PCL : S_PCH;
      K_RETI:        return (idx == 0) ? S_PSW : (idx == 1) ? S_PCL : S_PCH;
      default:       return S_DAT;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input logic up);
    return up ? p + PTR_W'(1) : p - PTR_W'(1);
  endfunction
endpackage

// File: rtl/stack_ptr.sv
module stack_ptr
  import stack_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step_en,
  input  logic             step_up,
  output logic [PTR_W-1:0] sp
);
  logic [PTR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= '0;
    else if (load_en) sp_q <= load_val;
    else if (step_en) sp_q <= ptr_step(sp_q, step_up);
  end

  assign sp = sp_q;
endmodule

// File: rtl/stack_frame_ctl.sv
module stack_frame_ctl
  import stack_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_req,
  input  logic            hold,
  output logic            busy,
  output logic            accept,
  output logic            wr_go,
  output logic            rd_go,
  output logic            done,
  output slot_t           slot
);
  logic             busy_q, drain_q, done_q;
  kind_t            kind_q;
  logic [IDX_W-1:0] idx_q;
  logic             step, last, writes;

  assign step   = busy_q && !drain_q;
  assign last   = (idx_q == frame_last(kind_q));
  assign writes = frame_writes(kind_q);
  assign accept = !busy_q && !hold && $onehot(op_req);
  assign wr_go  = step && writes;
  assign rd_go  = step && !writes;
  assign slot   = frame_slot(kind_q, idx_q);
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      drain_q <= 1'b0;
      done_q  <= 1'b0;
      kind_q  <= K_CALL;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        drain_q <= 1'b0;
        kind_q  <= decode_kind(op_req);
        idx_q   <= '0;
      end else if (step) begin
        if (!last) idx_q <= idx_q + IDX_W'(1);
        else if (writes) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else drain_q <= 1'b1;
      end else if (drain_q) begin
        busy_q  <= 1'b0;
        drain_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: the frame kind is frozen once a frame is under way
  assert_kind_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step) |=> (!busy_q || $stable(kind_q)));
endmodule

// File: rtl/stack_pop_capture.sv
module stack_pop_capture
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  slot_t             rd_slot,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pch,
  output logic [DATA_W-1:0] pcl,
  output logic [DATA_W-1:0] psw,
  output logic [DATA_W-1:0] dat
);
  logic  vld_q;
  slot_t dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= S_DAT;
      pch   <= '0;
      pcl   <= '0;
      psw   <= '0;
      dat   <= '0;
    end else begin
      vld_q <= rd_go;
      dst_q <= rd_slot;
      if (vld_q) begin
        case (dst_q)
          S_PCH:   pch <= rdata;
          S_PCL:   pcl <= rdata;
          S_PSW:   psw <= rdata;
          default: dat <= rdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [PTR_W-1:0] PAGE = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OP_W-1:0]         op_req,
  input  logic                    sp_load,
  input  logic [PTR_W-1:0]        sp_load_val,
  input  logic [PC_W-1:0]         pc_in,
  input  logic [DATA_W-1:0]       psw_in,
  input  logic [DATA_W-1:0]       data_in,
  output logic [PTR_W+PTR_W-1:0]  mem_addr,
  output logic                    mem_we,
  output logic                    mem_re,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic [PTR_W-1:0]        sp,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       pop_pch,
  output logic [DATA_W-1:0]       pop_pcl,
  output logic [DATA_W-1:0]       pop_psw,
  output logic [DATA_W-1:0]       pop_data
);
  logic              accept, wr_go, rd_go, load_en;
  slot_t             slot;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] psw_q, dat_q;

  stack_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .hold(sp_load),
    .busy(busy), .accept(accept), .wr_go(wr_go), .rd_go(rd_go),
    .done(done), .slot(slot)
  );

  assign load_en = sp_load && !busy;

  stack_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(sp_load_val),
    .step_en(wr_go || rd_go), .step_up(rd_go), .sp(sp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      psw_q <= '0;
      dat_q <= '0;
    end else if (accept) begin
      pc_q  <= pc_in;
      psw_q <= psw_in;
      dat_q <= data_in;
    end
  end

  always_comb begin
    case (slot)
      S_PCH:   mem_wdata = pc_q[PC_W-1:DATA_W];
      S_PCL:   mem_wdata = pc_q[DATA_W-1:0];
      S_PSW:   mem_wdata = psw_q;
      default: mem_wdata = dat_q;
    endcase
  end

  assign mem_we   = wr_go;
  assign mem_re   = rd_go;
  assign mem_addr = {PAGE, wr_go ? sp : ptr_step(sp, 1'b1)};

  stack_pop_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_slot(slot),
    .rdata(mem_rdata), .pch(pop_pch), .pcl(pop_pcl), .psw(pop_psw), .dat(pop_data)
  );

  // R2: write goes to the current pointer, which then drops by one
  assert_wr_then_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == ptr_step($past(mem_addr[PTR_W-1:0]), 1'b0));
  // R3: read address is where the pointer lands
  assert_rd_at_new_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(mem_addr[PTR_W-1:0]));
  // R9: never a read and a write together, never an access while idle
  assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));
  // R11: idle load lands in the pointer
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_load && !busy) |=> sp == $past(sp_load_val));
  // R14: restored outputs hold while idle
  assert_out_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({pop_pch, pop_pcl, pop_psw, pop_data}));
endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_req = '0;
  logic        sp_load = 1'b0;
  logic [7:0]  sp_load_val = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  psw_in = '0, data_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem_wdata, mem_rdata, sp, pop_pch, pop_pcl, pop_psw, pop_data;

  always #2.5 clk = ~clk;

  stack_seq uut (.*);

  // bench RAM: one page, data one cycle after the read strobe
  logic [7:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
  end

  int checks = 0, fails = 0;
  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  typedef struct { bit we; int addr; int wdata; } acc_t;
  acc_t q[$];
  bit   m_busy, m_drain, m_done, m_wr;
  int   m_sp, p;
  int   e_pch, e_pcl, e_psw, e_dat, n_pch, n_pcl, n_psw, n_dat;
  string tag;

  task automatic put(input int v);
    q.push_back('{1'b1, 256 + p, v});
    p = (p + 255) % 256;
  endtask
  task automatic get(output int v);
    p = (p + 1) % 256;
    q.push_back('{1'b0, 256 + p, 0});
    v = ram[p];
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_drain = 0; m_done = 0; m_sp = 0;
      e_pch = 0; e_pcl = 0; e_psw = 0; e_dat = 0;
    end else begin
      chk(busy, m_busy, "R9 busy");
      chk(done, m_done, "R9 done");
      chk(sp, m_sp, m_busy ? tag : "R11 pointer");
      if (!m_busy) begin
        chk({pop_pch, pop_pcl, pop_psw, pop_data},
            {8'(e_pch), 8'(e_pcl), 8'(e_psw), 8'(e_dat)}, "R14 outputs");
      end
      if (m_busy && !m_drain) begin
        chk({mem_we, mem_re}, {q[0].we, !q[0].we}, {tag, " strobes R9"});
        chk(mem_addr, q[0].addr, {tag, " address R1"});
        if (q[0].we) chk(mem_wdata, q[0].wdata, {tag, " data R13"});
      end else chk({mem_we, mem_re}, 2'b00, "R9 idle bus");
      // next state
      m_done = 0;
      if (m_busy) begin
        if (!m_drain) begin
          m_sp = q[0].we ? (m_sp + 255) % 256 : (m_sp + 1) % 256;
          void'(q.pop_front());
          if (q.size() == 0) begin
            if (m_wr) begin m_busy = 0; m_done = 1; end
            else m_drain = 1;
          end
        end else begin
          m_busy = 0; m_drain = 0; m_done = 1;
          e_pch = n_pch; e_pcl = n_pcl; e_psw = n_psw; e_dat = n_dat;
        end
      end else if (sp_load) begin
        m_sp = sp_load_val;
      end else if ($countones(op_req) == 1) begin
        p = m_sp; m_busy = 1;
        n_pch = e_pch; n_pcl = e_pcl; n_psw = e_psw; n_dat = e_dat;
        m_wr = op_req[0] | op_req[1] | op_req[4];
        if (op_req[0]) begin tag = "R4 call"; put(pc_in[15:8]); put(pc_in[7:0]); end
        if (op_req[1]) begin tag = "R5 irq"; put(pc_in[15:8]); put(pc_in[7:0]); put(psw_in); end
        if (op_req[2]) begin tag = "R6 ret"; get(n_pcl); get(n_pch); end
        if (op_req[3]) begin tag = "R7 reti"; get(n_psw); get(n_pcl); get(n_pch); end
        if (op_req[4]) begin tag = "R8 push"; put(data_in); end
        if (op_req[5]) begin tag = "R8 pop"; get(n_dat); end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); repeat (6) tick(); endtask
  task automatic issue(input logic [5:0] b); op_req = b; tick(); op_req = '0; endtask
  task automatic load(input logic [7:0] v);
    sp_load = 1; sp_load_val = v; tick(); sp_load = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    chk(sp, 8'h00, "R12 pointer"); chk(busy, 0, "R12 busy"); chk(done, 0, "R12 done");
    chk({pop_pch, pop_pcl, pop_psw, pop_data}, 0, "R12 outputs");
    chk({mem_we, mem_re}, 0, "R12 bus");
    tick();
    load(8'hFF); @(negedge clk); chk(sp, 8'hFF, "R11 load");
    tick();
    pc_in = 16'h1234; issue(6'b000001); settle();
    chk(sp, 8'hFD, "R4 pointer"); chk(ram[8'hFF], 8'h12, "R4 high first"); chk(ram[8'hFE], 8'h34, "R4 low");
    issue(6'b000100); settle();
    chk(pop_pch, 8'h12, "R6 pch"); chk(pop_pcl, 8'h34, "R6 pcl"); chk(sp, 8'hFF, "R6 pointer");
    pc_in = 16'hABCD; psw_in = 8'h5E; issue(6'b000010);
    pc_in = 16'h0000; psw_in = 8'h00; settle();
    chk(sp, 8'hFC, "R5 pointer"); chk(ram[8'hFD], 8'h5E, "R13 status kept");
    chk(ram[8'hFF], 8'hAB, "R13 pc kept");
    issue(6'b001000); settle();
    chk(pop_psw, 8'h5E, "R7 psw"); chk(pop_pch, 8'hAB, "R7 pch");
    chk(pop_pcl, 8'hCD, "R7 pcl"); chk(sp, 8'hFF, "R7 pointer");
    data_in = 8'h77; issue(6'b010000); data_in = 8'h00; settle();
    chk(ram[8'hFF], 8'h77, "R8 push"); chk(sp, 8'hFE, "R2 pointer");
    issue(6'b100000); settle();
    chk(pop_data, 8'h77, "R8 pop"); chk(sp, 8'hFF, "R3 pointer");
    data_in = 8'h11; issue(6'b010000); settle();
    chk(pop_data, 8'h77, "R14 data held"); chk(pop_pch, 8'hAB, "R14 pch held");
    // requests during a frame
    issue(6'b000010); op_req = 6'b000001; tick(); tick(); op_req = '0; settle();
    chk(sp, 8'hFB, "R10 busy ignore");
    op_req = 6'b000011; tick(); op_req = '0; @(negedge clk);
    chk(busy, 0, "R10 invalid request"); chk(sp, 8'hFB, "R10 pointer kept");
    tick();
    // load while busy, load with request
    issue(6'b000010); load(8'h40); settle();
    chk(sp, 8'hF8, "R11 busy load ignored");
    sp_load = 1; sp_load_val = 8'h80; op_req = 6'b010000; tick();
    sp_load = 0; op_req = '0; @(negedge clk);
    chk(busy, 0, "R11 request dropped"); chk(sp, 8'h80, "R11 load wins");
    tick();
    // wrap at both ends of the page
    load(8'h00); data_in = 8'h99; issue(6'b010000); settle();
    chk(sp, 8'hFF, "R1 wrap down"); chk(ram[8'h00], 8'h99, "R1 low byte 00");
    issue(6'b100000); settle();
    chk(sp, 8'h00, "R1 wrap up"); chk(pop_data, 8'h99, "R1 wrapped read");
    settle();
    summary();
    $finish;
  end
endmodule